// File: doc/BRIEF.md
# Serial Pixel and Depth Bank with Token Access

This block holds the colour and depth of a short run of pixels for one bit-serial span processor. Each pixel is a circular shift register. The processor reads and writes it one bit per clock: the stored bit leaves at the head, and the bit that replaces it enters at the tail. No address decoder is involved. A one-hot processor token marks the pixel in use. The token is loaded once with the first pixel of a span and then moves one pixel per slot, so only the first access of a span is random.

A slot is a fixed number of clocks. In its first `WORD_W` clocks the selected pixel turns once completely through its serial port, and in the remaining clocks it rests. Reading is destructive, so every bit that leaves must be written back. The bank decides during the turn whether the bit written back is the processor's new bit or the old one. With the depth test off, the new pixel is always taken. With it on, the depth arrives first, most significant bit first, and is compared on the fly. The new pixel is kept only when its depth is strictly nearer, meaning numerically smaller.

A second one-hot token serves the display side. Each video request returns one whole pixel and moves that token on, wrapping around the bank. This happens without stalling or disturbing the processor. When both tokens sit on the pixel that is being rewritten, the video side gets the value from before the write.

Top module: `serial_pixel_bank`

## Requirements
- R1: After reset every pixel holds depth all ones (farthest) and the background colour BG_R/BG_G/BG_B, the bank is not busy, and the video token points at pixel 0.
- R2: A pixel word is {z, r, g, b}, shifted most significant bit first, so z leads. In clock c of a slot with c < WORD_W, `bit_en` is high, `rd_bit` shows stored bit WORD_W-1-c and `wr_bit` is sampled. For the rest of the slot `bit_en` is low.
- R3: A `span_go` sampled while idle with `span_len` > 0 makes the next clock slot clock 0 of pixel `span_first`. Each further slot serves the next pixel up, and `busy` falls after `span_len` slots.
- R4: With the depth test on and a new z that is not smaller than the stored z (equal included), the pixel comes back unchanged after its slot.
- R5: With the depth test on and a new z strictly smaller than the stored z, the whole pixel (z, r, g, b) is replaced by the new bits.
- R6: With the depth test off, the whole pixel is replaced whatever the depths.
- R7: A `span_go` that arrives while busy, or that has `span_len` = 0, is ignored. The running span and the stored pixels stay as they would have been without it.
- R8: A `vid_req` sampled at a clock edge sets `vid_valid` for the next clock, with `vid_word` equal to the pixel under the video token. The token then moves to the next pixel and wraps from NPIX-1 to 0.
- R9: A video read of the pixel that is in its slot returns the value from before that slot's write. Video reads never change `rd_bit` or the stored pixels.
- R10: A span that would run past pixel NPIX-1 ends after that pixel's slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one bit per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| span_go | input | 1 | Start a span (taken only when idle) |
| span_first | input | IDX_W | Index of the first pixel of the span |
| span_len | input | IDX_W+1 | Number of pixels in the span |
| depth_en | input | 1 | Depth test for this span |
| wr_bit | input | 1 | New pixel bit for the current slot clock |
| rd_bit | output | 1 | Stored bit leaving the selected pixel |
| bit_en | output | 1 | A bit is exchanged this clock |
| busy | output | 1 | A span is in progress |
| vid_req | input | 1 | Video read request |
| vid_word | output | WORD_W | Pixel returned to the video side |
| vid_valid | output | 1 | `vid_word` is valid this clock |

## Verification
The serial exchange has no delay. `rd_bit` for slot clock c can be seen in that same clock, in the half-period after the edge that opened it. The bench therefore drives `wr_bit` and checks `rd_bit` at the falling edge inside each slot clock, and counts clocks from the edge that accepted `span_go`. A video answer comes one edge after the request, so the bench checks it at the next falling edge. That includes a request placed in the middle of a slot on the pixel being rewritten. Results that depend on the depth decision are read back through the video port only after the slot's last clock has passed, and the bench compares them with a model that applies the strict-nearer rule to whole words.

// File: rtl/spbank_pkg.sv
package spbank_pkg;

   // Running result of the MSB-first depth comparison.
   typedef enum logic [1:0] {
      CMP_EQ   = 2'd0,
      CMP_WIN  = 2'd1,
      CMP_LOSE = 2'd2
   } cmp_e;

   function automatic int idx_width(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/spbank_cell.sv
module spbank_cell #(
   parameter int             W    = 40,
   parameter logic [W-1:0]   INIT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift,
   input  logic         in_bit,
   output logic [W-1:0] word
);

   // Circular serial store: head is the MSB, the written bit enters the LSB.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         word <= INIT;
      else if (shift)
         word <= {word[W-2:0], in_bit};
   end

endmodule

// File: rtl/spbank_seq.sv
module spbank_seq
   import spbank_pkg::*;
#(
   parameter int NPIX     = 16,
   parameter int WORD_W   = 40,
   parameter int ZW       = 16,
   parameter int SLOT_LEN = 48,
   localparam int IDX_W   = idx_width(NPIX),
   localparam int CNT_W   = $clog2(SLOT_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              span_go,
   input  logic [IDX_W-1:0]  span_first,
   input  logic [IDX_W:0]    span_len,
   input  logic              depth_en,
   input  logic              wr_bit,
   input  logic              head_bit,
   input  logic [WORD_W-1:0] sel_word,
   output logic [NPIX-1:0]   tok,
   output logic              shift_en,
   output logic              wbit,
   output logic              busy,
   output logic              slot_open,
   output logic              slot_last,
   output logic [WORD_W-1:0] snap
);

   logic [CNT_W-1:0] bitc;
   logic [IDX_W:0]   remain;
   logic             depth_q;
   cmp_e             cmp, cmp_nxt;
   logic             accept, in_z;

   assign accept    = span_go && !busy && (span_len != '0);
   assign slot_last = busy && (bitc == CNT_W'(SLOT_LEN - 1));
   assign shift_en  = busy && (bitc < CNT_W'(WORD_W));
   assign in_z      = busy && (bitc < CNT_W'(ZW));
   assign slot_open = busy && (bitc != '0);

   // Bit-serial compare, MSB first: first differing bit settles the result.
   always_comb begin
      cmp_nxt = cmp;
      if (cmp == CMP_EQ) begin
         if (!wr_bit && head_bit)
            cmp_nxt = CMP_WIN;
         else if (wr_bit && !head_bit)
            cmp_nxt = CMP_LOSE;
      end
   end

   // Bit returned to the pixel tail.
   always_comb begin
      if (!depth_q)
         wbit = wr_bit;
      else if (in_z) begin
         unique case (cmp)
            CMP_WIN:  wbit = wr_bit;
            CMP_LOSE: wbit = head_bit;
            default:  wbit = wr_bit & head_bit;
         endcase
      end else
         wbit = (cmp == CMP_WIN) ? wr_bit : head_bit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         tok     <= '0;
         bitc    <= '0;
         remain  <= '0;
         depth_q <= 1'b0;
         cmp     <= CMP_EQ;
         snap    <= '0;
      end else if (accept) begin
         busy    <= 1'b1;
         tok     <= NPIX'(1) << span_first;
         bitc    <= '0;
         remain  <= span_len;
         depth_q <= depth_en;
         cmp     <= CMP_EQ;
      end else if (busy) begin
         if (bitc == '0)
            snap <= sel_word;
         if (in_z)
            cmp <= cmp_nxt;
         if (slot_last) begin
            bitc   <= '0;
            cmp    <= CMP_EQ;
            tok    <= tok << 1;
            remain <= remain - 1'b1;
            if (remain == (IDX_W+1)'(1) || tok[NPIX-1]) begin
               busy <= 1'b0;
               tok  <= '0;
            end
         end else
            bitc <= bitc + 1'b1;
      end
   end

endmodule

// File: rtl/spbank_video.sv
module spbank_video #(
   parameter int NPIX   = 16,
   parameter int WORD_W = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vid_req,
   input  logic [WORD_W-1:0] words [NPIX],
   input  logic [NPIX-1:0]   tok,
   input  logic              slot_open,
   input  logic [WORD_W-1:0] snap,
   output logic [NPIX-1:0]   vtok,
   output logic [WORD_W-1:0] vid_word,
   output logic              vid_valid
);

   logic [WORD_W-1:0] vsel;
   logic              hit;

   always_comb begin
      vsel = '0;
      for (int i = 0; i < NPIX; i++)
         if (vtok[i]) vsel = vsel | words[i];
   end

   // Pixel mid-rotation under both tokens: serve the pre-write copy.
   assign hit = slot_open && ((vtok & tok) != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vtok      <= NPIX'(1);
         vid_word  <= '0;
         vid_valid <= 1'b0;
      end else begin
         vid_valid <= vid_req;
         if (vid_req) begin
            vid_word <= hit ? snap : vsel;
            vtok     <= {vtok[NPIX-2:0], vtok[NPIX-1]};
         end
      end
   end

endmodule

// File: rtl/serial_pixel_bank.sv
module serial_pixel_bank
   import spbank_pkg::*;
#(
   parameter int             NPIX     = 16,
   parameter int             RW       = 8,
   parameter int             GW       = 8,
   parameter int             BW       = 8,
   parameter int             ZW       = 16,
   parameter int             SLOT_LEN = 48,
   parameter logic [RW-1:0]  BG_R     = 'h10,
   parameter logic [GW-1:0]  BG_G     = 'h20,
   parameter logic [BW-1:0]  BG_B     = 'h30,
   localparam int            WORD_W   = ZW + RW + GW + BW,
   localparam int            IDX_W    = idx_width(NPIX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              span_go,
   input  logic [IDX_W-1:0]  span_first,
   input  logic [IDX_W:0]    span_len,
   input  logic              depth_en,
   input  logic              wr_bit,
   output logic              rd_bit,
   output logic              bit_en,
   output logic              busy,
   input  logic              vid_req,
   output logic [WORD_W-1:0] vid_word,
   output logic              vid_valid
);

   localparam logic [WORD_W-1:0] INIT_W = {{ZW{1'b1}}, BG_R, BG_G, BG_B};

   if (SLOT_LEN < WORD_W) begin : g_bad_slot
      $error("SLOT_LEN must cover one full pixel rotation");
   end
   if (NPIX < 2) begin : g_bad_npix
      $error("NPIX must be at least 2");
   end

   logic [WORD_W-1:0] words [NPIX];
   logic [NPIX-1:0]   heads, tok, vtok;
   logic [WORD_W-1:0] sel_word, snap;
   logic              head_bit, wbit, shift_en, slot_open, slot_last;

   for (genvar gi = 0; gi < NPIX; gi++) begin : g_pix
      spbank_cell #(.W(WORD_W), .INIT(INIT_W)) u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .shift  (shift_en & tok[gi]),
         .in_bit (wbit),
         .word   (words[gi])
      );
      assign heads[gi] = words[gi][WORD_W-1];
   end

   assign head_bit = |(heads & tok);

   always_comb begin
      sel_word = '0;
      for (int i = 0; i < NPIX; i++)
         if (tok[i]) sel_word = sel_word | words[i];
   end

   spbank_seq #(
      .NPIX(NPIX), .WORD_W(WORD_W), .ZW(ZW), .SLOT_LEN(SLOT_LEN)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .span_go    (span_go),
      .span_first (span_first),
      .span_len   (span_len),
      .depth_en   (depth_en),
      .wr_bit     (wr_bit),
      .head_bit   (head_bit),
      .sel_word   (sel_word),
      .tok        (tok),
      .shift_en   (shift_en),
      .wbit       (wbit),
      .busy       (busy),
      .slot_open  (slot_open),
      .slot_last  (slot_last),
      .snap       (snap)
   );

   spbank_video #(.NPIX(NPIX), .WORD_W(WORD_W)) u_vid (
      .clk       (clk),
      .rst_n     (rst_n),
      .vid_req   (vid_req),
      .words     (words),
      .tok       (tok),
      .slot_open (slot_open),
      .snap      (snap),
      .vtok      (vtok),
      .vid_word  (vid_word),
      .vid_valid (vid_valid)
   );

   assign rd_bit = head_bit;
   assign bit_en = shift_en;

endmodule

// File: rtl/serial_pixel_bank_chk.sv
module serial_pixel_bank_chk #(
   parameter int NPIX  = 16,
   parameter int LEN_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             span_go,
   input logic [LEN_W-1:0] span_len,
   input logic             busy,
   input logic             bit_en,
   input logic             vid_req,
   input logic             vid_valid,
   input logic             slot_last,
   input logic [NPIX-1:0]  tok,
   input logic [NPIX-1:0]  vtok
);

   a_r3_token_single: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ($countones(tok) == 1));

   a_r3_span_start: assert property (@(posedge clk) disable iff (!rst_n)
      (span_go && !busy && span_len != '0) |=> (busy && bit_en));

   a_r7_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && span_go && !slot_last) |=> $stable(tok));

   a_r2_shift_in_span: assert property (@(posedge clk) disable iff (!rst_n)
      bit_en |-> busy);

   a_r8_vid_answer: assert property (@(posedge clk) disable iff (!rst_n)
      vid_req |=> vid_valid);

   a_r8_vid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !vid_req |=> !vid_valid);

   a_r8_vtok_single: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(vtok) == 1);

   a_r10_stop_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_last && tok[NPIX-1]) |=> !busy);

endmodule

bind serial_pixel_bank serial_pixel_bank_chk #(.NPIX(NPIX), .LEN_W(IDX_W + 1)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .span_go   (span_go),
   .span_len  (span_len),
   .busy      (busy),
   .bit_en    (bit_en),
   .vid_req   (vid_req),
   .vid_valid (vid_valid),
   .slot_last (slot_last),
   .tok       (tok),
   .vtok      (vtok)
);

// File: tb/serial_pixel_bank_bench.sv
module serial_pixel_bank_bench;

   localparam int NPIX  = 16;
   localparam int ZW    = 16;
   localparam int W     = 40;
   localparam int SLOT  = 48;
   localparam logic [W-1:0] BG = {16'hFFFF, 8'h10, 8'h20, 8'h30};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         span_go = 1'b0;
   logic [3:0]   span_first = '0;
   logic [4:0]   span_len = '0;
   logic         depth_en = 1'b0;
   logic         wr_bit = 1'b0;
   logic         vid_req = 1'b0;
   logic         rd_bit, bit_en, busy, vid_valid;
   logic [W-1:0] vid_word;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [W-1:0] mdl [NPIX];
   int vptr = 0;

   always #4 clk = ~clk;

   serial_pixel_bank u_serial_pixel_bank (
      .clk(clk), .rst_n(rst_n), .span_go(span_go), .span_first(span_first),
      .span_len(span_len), .depth_en(depth_en), .wr_bit(wr_bit),
      .rd_bit(rd_bit), .bit_en(bit_en), .busy(busy), .vid_req(vid_req),
      .vid_word(vid_word), .vid_valid(vid_valid)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] mk(input int pix, input int seed, input logic [ZW-1:0] z);
      return {z, 8'(pix * 7 + seed), 8'(seed * 3 + 1), 8'(pix ^ seed)};
   endfunction

   // One video read, answer checked at the next falling edge (R8).
   task automatic vid_read(input string req);
      @(negedge clk) vid_req = 1'b1;
      @(negedge clk) vid_req = 1'b0;
      chk(vid_valid == 1'b1, "R8 valid", 64'(vid_valid), 64'd1);
      chk(vid_word == mdl[vptr], req, 64'(vid_word), 64'(mdl[vptr]));
      vptr = (vptr + 1) % NPIX;
   endtask

   // Drive one span; optional mid-span retry and a video read at (vp, vc).
   task automatic run_span(input int first, input int len, input bit dep, input int seed,
                           input logic [ZW-1:0] zv [8], input bit retry,
                           input int vp, input int vc);
      @(negedge clk);
      span_go = 1'b1; span_first = 4'(first); span_len = 5'(len); depth_en = dep;
      @(negedge clk);
      span_go = 1'b0; depth_en = 1'b0;
      for (int p = 0; p < len && first + p < NPIX; p++) begin
         int idx = first + p;
         logic [W-1:0] nw = mk(idx, seed, zv[p]);
         logic [W-1:0] ow = mdl[idx];
         for (int c = 0; c < SLOT; c++) begin
            wr_bit = (c < W) ? nw[W-1-c] : 1'b0;
            if (c < W) begin
               chk(bit_en == 1'b1, "R2 bit_en", 64'(bit_en), 64'd1);
               chk(rd_bit == ow[W-1-c], "R2 rd_bit", 64'(rd_bit), 64'(ow[W-1-c]));
            end else if (c == W)
               chk(bit_en == 1'b0, "R2 rest", 64'(bit_en), 64'd0);
            if (retry && p == 0 && c == 5) begin
               span_go = 1'b1; span_first = 4'd0; span_len = 5'd3; depth_en = 1'b1;
            end
            if (retry && p == 0 && c == 6) begin
               span_go = 1'b0; depth_en = 1'b0;
            end
            if (p == vp && c == vc) vid_req = 1'b1;
            if (p == vp && c == vc + 1) begin
               vid_req = 1'b0;
               chk(vid_valid == 1'b1, "R9 valid", 64'(vid_valid), 64'd1);
               chk(vid_word == ow, "R9 pre-write", 64'(vid_word), 64'(ow));
               vptr = (vptr + 1) % NPIX;
            end
            @(negedge clk);
         end
         if (!dep || nw[W-1 -: ZW] < ow[W-1 -: ZW]) mdl[idx] = nw;
      end
      wr_bit = 1'b0;
      chk(busy == 1'b0, "R3 R10 end", 64'(busy), 64'd0);
   endtask

   task automatic t_reset;
      chk(busy == 1'b0, "R1 busy", 64'(busy), 64'd0);
      chk(vid_valid == 1'b0, "R1 vid_valid", 64'(vid_valid), 64'd0);
      for (int i = 0; i < NPIX; i++) vid_read("R1 background");
      vid_read("R8 wrap");
   endtask

   task automatic t_depth_off;
      run_span(2, 4, 1'b0, 5, '{16'h4000, 16'h4000, 16'h4000, 16'h4000, 0, 0, 0, 0}, 1'b0, -1, 0);
   endtask

   task automatic t_depth_on;
      // pixels 2..5 hold z 4000, 6..7 hold FFFF
      run_span(2, 6, 1'b1, 9, '{16'h3FFF, 16'h4000, 16'h4001, 16'h0100,
                                16'h8000, 16'hFFFF, 0, 0}, 1'b0, -1, 0);
   endtask

   task automatic t_ignore;
      @(negedge clk);
      span_go = 1'b1; span_first = 4'd0; span_len = 5'd0;
      @(negedge clk) span_go = 1'b0;
      chk(busy == 1'b0, "R7 zero length", 64'(busy), 64'd0);
      run_span(12, 2, 1'b0, 11, '{16'h0001, 16'h0002, 0, 0, 0, 0, 0, 0}, 1'b1, -1, 0);
   endtask

   task automatic t_bank_end;
      run_span(14, 5, 1'b0, 13, '{16'h0030, 16'h0031, 16'h0032, 16'h0033, 16'h0034, 0, 0, 0},
               1'b0, -1, 0);
   endtask

   task automatic t_collision;
      while (vptr != 3) vid_read("R8 step");
      run_span(3, 1, 1'b0, 17, '{16'h0777, 0, 0, 0, 0, 0, 0, 0}, 1'b0, 0, 20);
   endtask

   task automatic t_dump;
      for (int i = 0; i < NPIX; i++) vid_read("R4 R5 R6 R7 R9 contents");
   endtask

   initial begin
      for (int i = 0; i < NPIX; i++) mdl[i] = BG;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_depth_off();
      t_depth_on();
      t_ignore();
      t_bank_end();
      t_collision();
      t_dump();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      end
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      end
      $finish;
   end

endmodule